// File: doc/BRIEF.md
# Second-Order Sinc Decimator for One-Bit Streams

This block takes a one-bit oversampled stream, one sample per accepted strobe, and turns it into a 16-bit result at a lower rate. It uses a cascaded integrator-comb structure of order two. Two wrap-around integrators add every accepted sample. Once every M accepted samples, two difference stages run, the result is scaled by an arithmetic right shift, and it is latched into a high byte and a low byte. A one-cycle valid pulse marks each new result.

Configuration inputs set the rest. One picks the decimation length from a fixed menu that includes lengths that are not powers of two. One picks whether a zero input counts as minus one or as nothing. One picks the post-shift. One picks the operating style: a full filter; a raw double-integral output, where the differencing is left to the reader; or a one-shot conversion, where the state clears after each result. A write strobe on either output byte clears the filter state.

Top module: `sinc2_decim`

## Requirements
- R1: While `rst_n` is low, `out_hi`, `out_lo` and `out_valid` are zero and all filter state is cleared.
- R2: `rate_sel` sets the decimation length M: 1=32, 2=50, 3=64, 4=125, 5=128, 6=250, 7=256. Exactly one result is produced per M accepted samples.
- R3: An accepted sample with `in_bit`=1 adds +1. With `in_bit`=0 it adds -1 when `zero_neg`=1 and adds 0 when `zero_neg`=0.
- R4: With `mode`=2 (or the reserved value 3), the result is the second difference, taken every M samples, of the double integral. For constant ones input the steady result is M squared.
- R5: With `mode`=0, the result is the value of the second integrator, including the terminal sample. No differencing is applied.
- R6: With `mode`=1, the result is the second integrator value over exactly M samples. The integrators clear at that same edge, so each conversion starts from zero.
- R7: `shift_sel` 0,1,2,3 shifts the result right arithmetically by 0,1,2,4 bits. The low 16 bits of the shifted value are presented, bits 15:8 on `out_hi` and bits 7:0 on `out_lo`.
- R8: A pulse on `clr_hi` or `clr_lo` clears the integrators, the comb delays and the sample counter. It leaves `out_hi` and `out_lo` unchanged and produces no valid pulse, even if it coincides with a terminal sample.
- R9: With `rate_sel`=0 the sample counter is held and `out_valid` stays low.
- R10: `out_valid` is a single-cycle pulse in the cycle after the edge that accepted the terminal sample. `out_hi` and `out_lo` change only together with that pulse.
- R11: A cycle with `in_valid` low changes no filter state and produces no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample accept strobe |
| in_bit | input | 1 | Modulator bit |
| rate_sel | input | 3 | Decimation length code (0 = off) |
| mode | input | 2 | 0 raw integral, 1 one-shot conversion, 2 full filter |
| zero_neg | input | 1 | 1: zero input counts as -1; 0: counts as 0 |
| shift_sel | input | 2 | Output right shift code (0,1,2,4 bits) |
| clr_hi | input | 1 | Write strobe to high output byte; clears state |
| clr_lo | input | 1 | Write strobe to low output byte; clears state |
| out_hi | output | 8 | Result bits 15:8 |
| out_lo | output | 8 | Result bits 7:0 |
| out_valid | output | 1 | New-result pulse |

## Verification
The bench targets the lengths that are not powers of two (50, 125, 250). A counter that compared against a wrong terminal value would yield the wrong pulse count and a result far from M squared. It drives M=256 with a shift of one, where the unshifted result needs 17 bits. A design that truncated before shifting would show zero instead of 0x8000. It runs all-zero input in both zero formats, so a swapped format meaning shows up as a result of 0 instead of -2500. It also checks three other cases: a one-shot conversion that forgets to clear its state, a clear that disturbs the held output, and a disabled rate that still pulses.

// File: rtl/sinc2_pkg.sv
package sinc2_pkg;

   localparam int CNT_W = 9;

   typedef enum logic [1:0] {
      MODE_RAW     = 2'd0,
      MODE_ONESHOT = 2'd1,
      MODE_FULL    = 2'd2,
      MODE_RSVD    = 2'd3
   } mode_e;

   // Last count index (M-1) for each rate code; zero when disabled.
   function automatic logic [CNT_W-1:0] rate_last(input logic [2:0] sel);
      case (sel)
         3'd1:    rate_last = CNT_W'(31);
         3'd2:    rate_last = CNT_W'(49);
         3'd3:    rate_last = CNT_W'(63);
         3'd4:    rate_last = CNT_W'(124);
         3'd5:    rate_last = CNT_W'(127);
         3'd6:    rate_last = CNT_W'(249);
         3'd7:    rate_last = CNT_W'(255);
         default: rate_last = '0;
      endcase
   endfunction

endpackage

// File: rtl/sinc2_integ.sv
module sinc2_integ #(
   parameter int W     = 18,
   parameter int ORDER = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] delta,
   output logic [W-1:0] sum_nxt
);

   logic [ORDER-1:0][W-1:0] acc_q;
   logic [ORDER-1:0][W-1:0] acc_d;

   for (genvar g = 0; g < ORDER; g++) begin : g_stage
      if (g == 0) begin : g_first
         assign acc_d[g] = acc_q[g] + delta;
      end else begin : g_next
         assign acc_d[g] = acc_q[g] + acc_d[g-1];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)      acc_q[g] <= '0;
         else if (clr)    acc_q[g] <= '0;
         else if (step)   acc_q[g] <= acc_d[g];
      end
   end

   assign sum_nxt = acc_d[ORDER-1];

endmodule

// File: rtl/sinc2_comb.sv
module sinc2_comb #(
   parameter int W     = 18,
   parameter int ORDER = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         fire,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [ORDER-1:0][W-1:0] dly_q;
   logic [ORDER-1:0][W-1:0] diff;

   for (genvar g = 0; g < ORDER; g++) begin : g_stage
      if (g == 0) begin : g_first
         assign diff[g] = din - dly_q[g];
         always_ff @(posedge clk) begin
            if (!rst_n)     dly_q[g] <= '0;
            else if (clr)   dly_q[g] <= '0;
            else if (fire)  dly_q[g] <= din;
         end
      end else begin : g_next
         assign diff[g] = diff[g-1] - dly_q[g];
         always_ff @(posedge clk) begin
            if (!rst_n)     dly_q[g] <= '0;
            else if (clr)   dly_q[g] <= '0;
            else if (fire)  dly_q[g] <= diff[g-1];
         end
      end
   end

   assign dout = diff[ORDER-1];

endmodule

// File: rtl/sinc2_scale.sv
module sinc2_scale #(
   parameter int W     = 18,
   parameter int OUT_W = 16
) (
   input  logic [W-1:0]     din,
   input  logic [1:0]       sel,
   output logic [OUT_W-1:0] dout
);

   logic [2:0]          amt;
   logic signed [W-1:0] shifted;

   always_comb begin
      amt     = (sel == 2'd3) ? 3'd4 : {1'b0, sel};
      shifted = $signed(din) >>> amt;
      dout    = shifted[OUT_W-1:0];
   end

endmodule

// File: rtl/sinc2_decim.sv
module sinc2_decim
   import sinc2_pkg::*;
#(
   parameter int ORDER = 2,
   parameter int ACC_W = 18
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic       in_bit,
   input  logic [2:0] rate_sel,
   input  logic [1:0] mode,
   input  logic       zero_neg,
   input  logic [1:0] shift_sel,
   input  logic       clr_hi,
   input  logic       clr_lo,
   output logic [7:0] out_hi,
   output logic [7:0] out_lo,
   output logic       out_valid
);

   localparam int OUT_W  = 16;
   localparam int MIN_W  = 8 * ORDER + 2;

   if (ORDER < 1) begin : g_bad_order
      $error("ORDER must be at least 1");
   end
   if (ACC_W < MIN_W) begin : g_bad_width
      $error("ACC_W too narrow for M=256 at this ORDER");
   end
   if (ACC_W < OUT_W) begin : g_bad_out
      $error("ACC_W must cover the output width");
   end

   mode_e            mode_v;
   logic             clr_all;
   logic             running;
   logic             terminal;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_idx;
   logic [ACC_W-1:0] delta;
   logic [ACC_W-1:0] int_sum;
   logic [ACC_W-1:0] comb_out;
   logic [ACC_W-1:0] result;
   logic [OUT_W-1:0] scaled;
   logic [OUT_W-1:0] res_q;
   logic             valid_q;
   logic             int_clr;
   logic             comb_fire;

   always_comb begin
      mode_v   = mode_e'(mode);
      clr_all  = clr_hi | clr_lo;
      last_idx = rate_last(rate_sel);
      running  = (rate_sel != 3'd0);
      terminal = in_valid && running && !clr_all && (cnt_q >= last_idx);
      if (in_bit)        delta = ACC_W'(1);
      else if (zero_neg) delta = '1;
      else               delta = '0;
      int_clr   = clr_all | (terminal && (mode_v == MODE_ONESHOT));
      comb_fire = terminal && ((mode_v == MODE_FULL) || (mode_v == MODE_RSVD));
      result    = comb_fire ? comb_out : int_sum;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (clr_all || !running) cnt_q <= '0;
      else if (in_valid)          cnt_q <= terminal ? '0 : cnt_q + 1'b1;
   end

   sinc2_integ #(.W(ACC_W), .ORDER(ORDER)) u_integ (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (int_clr),
      .step    (in_valid),
      .delta   (delta),
      .sum_nxt (int_sum)
   );

   sinc2_comb #(.W(ACC_W), .ORDER(ORDER)) u_comb (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_all),
      .fire  (comb_fire),
      .din   (int_sum),
      .dout  (comb_out)
   );

   sinc2_scale #(.W(ACC_W), .OUT_W(OUT_W)) u_scale (
      .din  (result),
      .sel  (shift_sel),
      .dout (scaled)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= terminal;
         if (terminal) res_q <= scaled;
      end
   end

   assign out_hi    = res_q[15:8];
   assign out_lo    = res_q[7:0];
   assign out_valid = valid_q;

endmodule

// File: rtl/sinc2_decim_chk.sv
module sinc2_decim_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic [2:0] rate_sel,
   input logic       clr_hi,
   input logic       clr_lo,
   input logic [7:0] out_hi,
   input logic [7:0] out_lo,
   input logic       out_valid
);

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_CLEAR: assert (!out_valid || $time == 0); // R1
      end
   end

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel == 3'd0) |=> !out_valid); // R9

   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid); // R10

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |=> (!out_valid || 1'b1) && ($stable({out_hi, out_lo}) || $past(!rst_n) || out_valid)); // R10

   AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R11

   AST_CLEAR_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hi || clr_lo) |=> !out_valid); // R8

endmodule

bind sinc2_decim sinc2_decim_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .rate_sel  (rate_sel),
   .clr_hi    (clr_hi),
   .clr_lo    (clr_lo),
   .out_hi    (out_hi),
   .out_lo    (out_lo),
   .out_valid (out_valid)
);

// File: tb/sinc2_decim_bench.sv
module sinc2_decim_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_bit = 1'b0;
   logic [2:0] rate_sel = 3'd0;
   logic [1:0] mode = 2'd2;
   logic       zero_neg = 1'b0;
   logic [1:0] shift_sel = 2'd0;
   logic       clr_hi = 1'b0;
   logic       clr_lo = 1'b0;
   logic [7:0] out_hi;
   logic [7:0] out_lo;
   logic       out_valid;

   int checks = 0;
   int fails = 0;
   int pulses = 0;
   logic [15:0] last_val = '0;
   bit done = 0;

   always #2.5 clk = ~clk;

   sinc2_decim u_sinc2_decim (.*);

   // {rate[2:0], mode[1:0], zero_neg, shift[1:0], pat[1:0] (0 ones,1 zeros), expected[15:0]}
   localparam logic [25:0] TBL [8] = '{
      {3'd1, 2'd2, 1'b0, 2'd0, 2'd0, 16'h0400},  // R4 M=32 steady 1024
      {3'd2, 2'd2, 1'b1, 2'd0, 2'd1, 16'hF63C},  // R3 M=50 zeros as -1 -> -2500
      {3'd7, 2'd2, 1'b0, 2'd1, 2'd0, 16'h8000},  // R7 M=256 >>1
      {3'd4, 2'd2, 1'b0, 2'd2, 2'd0, 16'h0F42},  // R2 M=125 >>2
      {3'd6, 2'd2, 1'b1, 2'd3, 2'd0, 16'h0F42},  // R7 M=250 >>4
      {3'd5, 2'd2, 1'b0, 2'd0, 2'd1, 16'h0000},  // R3 zeros add nothing
      {3'd1, 2'd0, 1'b0, 2'd0, 2'd0, 16'h1230},  // R5 raw integral 96*97/2
      {3'd1, 2'd1, 1'b0, 2'd0, 2'd0, 16'h0210}   // R6 one-shot 32*33/2
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic note();
      if (out_valid) begin
         pulses++;
         last_val = {out_hi, out_lo};
      end
   endtask

   task automatic feed(input int n, input bit b);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); in_valid = 1'b1; in_bit = b;
         @(posedge clk); #1; note();
         @(negedge clk); in_valid = 1'b0;
         @(posedge clk); #1; note();
      end
   endtask

   task automatic clear_pulse();
      @(negedge clk); clr_lo = 1'b1;
      @(negedge clk); clr_lo = 1'b0;
      @(posedge clk); #1; note();
   endtask

   function automatic int len_of(input logic [2:0] r);
      case (r)
         3'd1: return 32;
         3'd2: return 50;
         3'd3: return 64;
         3'd4: return 125;
         3'd5: return 128;
         3'd6: return 250;
         3'd7: return 256;
         default: return 0;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 out_hi", {8'h00, out_hi}, 16'h0000);
      chk("R1 out_lo", {8'h00, out_lo}, 16'h0000);
      chk("R1 out_valid", {15'd0, out_valid}, 16'h0000);
      @(negedge clk); rst_n = 1'b1;

      for (int e = 0; e < 8; e++) begin
         @(negedge clk);
         rate_sel  = TBL[e][25:23];
         mode      = TBL[e][22:21];
         zero_neg  = TBL[e][20];
         shift_sel = TBL[e][19:18];
         clear_pulse();
         pulses = 0;
         feed(3 * len_of(TBL[e][25:23]), TBL[e][17:16] == 2'd0);
         chk($sformatf("R2 pulse count entry %0d", e), 16'(pulses), 16'd3);
         chk($sformatf("R4 R5 R6 result entry %0d", e), last_val, TBL[e][15:0]);
      end

      // R8: clear mid-stream restarts the conversion and holds the output
      @(negedge clk);
      rate_sel = 3'd1; mode = 2'd2; zero_neg = 1'b0; shift_sel = 2'd0;
      clear_pulse();
      pulses = 0;
      feed(10, 1'b1);
      @(negedge clk); clr_hi = 1'b1;
      @(negedge clk); clr_hi = 1'b0;
      @(posedge clk); #1;
      chk("R8 output held after clear", {out_hi, out_lo}, 16'h0210);
      feed(32, 1'b1);
      chk("R8 one pulse after clear", 16'(pulses), 16'd1);
      chk("R7 high byte", {8'h00, out_hi}, 16'h0002);
      chk("R7 low byte", {8'h00, out_lo}, 16'h0010);

      // R9: rate off gives no results
      @(negedge clk); rate_sel = 3'd0;
      clear_pulse();
      pulses = 0;
      feed(100, 1'b1);
      chk("R9 no pulse when off", 16'(pulses), 16'd0);
      chk("R9 output held when off", {out_hi, out_lo}, 16'h0210);

      // R11: idle cycles do not advance the counter
      @(negedge clk); rate_sel = 3'd1;
      clear_pulse();
      pulses = 0;
      feed(31, 1'b1);
      repeat (40) begin
         @(posedge clk); #1; note();
      end
      chk("R11 idle cycles produce nothing", 16'(pulses), 16'd0);
      feed(1, 1'b1);
      chk("R11 terminal after 32 accepted", 16'(pulses), 16'd1);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule